// File: doc/BRIEF.md
# Open-Loop Performance-Level Voltage Controller

This block sits between an energy-management policy unit, an external power-supply unit and the clock manager. It receives a target performance level as a thermometer code. It looks up the supply-voltage code for that level in a programmable table and hands the code to the supply over a parallel request/acknowledge port. Once the new voltage is confirmed as usable, it reports the level now in force back to the clock manager, also as a thermometer code.

The block confirms a new voltage in one of two ways. It can wait a programmable number of cycles, or it can query the supply and wait for its ready indication. It can walk the levels one at a time, so that each intermediate step is confirmed and reported. When performance rises, the voltage changes before the level is reported. When performance falls, the level is reported first and the voltage is lowered afterwards. An all-zero request selects the retention (sleep) level, which has its own table entry.

A small synchronous register port gives access to the table, the settling timeout, the mode bits and a read-only revision word.

Top module: `dvs_level_ctrl`

## Requirements
- R1: The level is the number of ones in an 8-bit thermometer code, so 0 ones is the retention level and 8 ones is the top level. After reset the reported level is 8'h01, the psu_code is the reset table entry for level 1 (8'h30), psu_req is low and the error flag is clear.
- R2: A request with a 0 above a 1 (for example 8'h05) is ignored. The target, the reported level and the supply port are left untouched, and therm_err is set by the edge that sampled the request and stays set until reset.
- R3: Register addresses 0 to 8 hold the voltage codes for levels 0 to 8. Entry i resets to 8'h20 + 16*i. A write updates the entry, a read returns it on the edge that samples reg_re, and later transitions use the new value.
- R4: For a transition, psu_req rises one edge after the request is sampled. psu_code carries the table entry of the level being entered, and psu_req stays high with a stable code until psu_ack is sampled high, then falls on that edge.
- R5: In timer mode (control bit 0 = 0), with timeout T at address 9, a rising request sampled at edge E0 changes the reported level at edge E0+3+T and not before.
- R6: In polling mode (control bit 0 = 1), psu_query is high while the block waits after the acknowledge. The reported level rises on the first edge that samples psu_vdd_ok high.
- R7: A falling request sampled at edge E0 changes the reported level at edge E0+1, on the same edge that raises psu_req with the lower code.
- R8: In step mode (control bit 1 = 1), each transition moves one level. Each intermediate level is confirmed and reported in turn, so one hop in timer mode takes 3+T cycles.
- R9: An all-zero request drives the retention entry (address 0) onto psu_code and reports level 0.
- R10: A request that arrives during a transition is held and serviced once the transition ends. Only the most recent valid request is kept.
- R11: Address 11 reads the revision word 16'h0102, and writes to it have no effect.
- R12: Address 9 (timeout) and address 10 (bit 0 polling, bit 1 step) read back their stored values. Reset values are 4 and 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Level request strobe |
| req_therm | input | 8 | Requested level, thermometer code |
| cur_therm | output | 8 | Level in force, thermometer code |
| therm_err | output | 1 | Sticky malformed-request flag |
| psu_req | output | 1 | Voltage change request to supply |
| psu_code | output | 8 | Voltage code to supply |
| psu_ack | input | 1 | Supply has taken the code |
| psu_query | output | 1 | Asking supply for ready status |
| psu_vdd_ok | input | 1 | Supply voltage ready |
| reg_we | input | 1 | Register write enable |
| reg_re | input | 1 | Register read enable |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, registered |

## Verification
The bench counts edges from the one that samples a request. psu_req is due one edge later. A falling level is reported on that same edge. A rising level is due 3+T edges after the request in timer mode, and one edge after psu_vdd_ok is seen high in polling mode. Each timing check samples on the falling clock edge just before and just after the due edge, so both an early change and a late change are caught. A register read is due on the edge that samples reg_re. The table-driven runs wait well past every settling window before they compare the final level and code.

// File: rtl/dvs_level_ctrl.sv
module dvs_level_ctrl #(
  parameter int NUM_LVL = 8,
  parameter int VW = 8,
  parameter int TW = 16,
  parameter int DW = 16,
  parameter int AW = 4,
  parameter logic [DW-1:0] REV_ID = 16'h0102,
  parameter logic [VW-1:0] VBASE = 8'h20,
  parameter logic [VW-1:0] VSTEP = 8'h10,
  parameter logic [TW-1:0] TMO_RST = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [NUM_LVL-1:0] req_therm,
  output logic [NUM_LVL-1:0] cur_therm,
  output logic               therm_err,
  output logic               psu_req,
  output logic [VW-1:0]      psu_code,
  input  logic               psu_ack,
  output logic               psu_query,
  input  logic               psu_vdd_ok,
  input  logic               reg_we,
  input  logic               reg_re,
  input  logic [AW-1:0]      reg_addr,
  input  logic [DW-1:0]      reg_wdata,
  output logic [DW-1:0]      reg_rdata
);
  localparam int LW    = $clog2(NUM_LVL + 1);
  localparam int A_TMO = NUM_LVL + 1;
  localparam int A_CTL = NUM_LVL + 2;
  localparam int A_REV = NUM_LVL + 3;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_SET} st_t;

  st_t             st;
  logic [LW-1:0]   cur_lvl, tgt_lvl, nxt_lvl, hop, req_lvl, tidx;
  logic            up_r, go_up, ctl_poll, ctl_step, req_ok, settle_done;
  logic [TW-1:0]   cnt, tmo;
  logic [NUM_LVL-1:0] req_inc;
  logic [VW-1:0]   vtab [0:NUM_LVL];
  logic [DW-1:0]   rd_mux;

  assign req_inc     = req_therm + 1'b1;
  assign req_ok      = (req_inc & req_therm) == '0;
  assign req_lvl     = LW'($countones(req_therm));
  assign go_up       = tgt_lvl > cur_lvl;
  assign hop         = ctl_step ? (go_up ? cur_lvl + 1'b1 : cur_lvl - 1'b1) : tgt_lvl;
  assign settle_done = ctl_poll ? psu_vdd_ok : (cnt == tmo);
  assign psu_query   = (st == ST_SET) && ctl_poll;
  assign tidx        = reg_addr[LW-1:0];

  for (genvar i = 0; i < NUM_LVL; i++) begin : g_therm
    assign cur_therm[i] = cur_lvl > LW'(i);
  end

  always_comb begin
    rd_mux = '0;
    if (reg_addr <= AW'(NUM_LVL)) rd_mux = DW'(vtab[tidx]);
    else if (reg_addr == AW'(A_TMO)) rd_mux = DW'(tmo);
    else if (reg_addr == AW'(A_CTL)) rd_mux = DW'({ctl_step, ctl_poll});
    else if (reg_addr == AW'(A_REV)) rd_mux = REV_ID;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      cur_lvl   <= LW'(1);
      tgt_lvl   <= LW'(1);
      nxt_lvl   <= LW'(1);
      up_r      <= 1'b0;
      cnt       <= '0;
      tmo       <= TMO_RST;
      ctl_poll  <= 1'b0;
      ctl_step  <= 1'b0;
      therm_err <= 1'b0;
      psu_req   <= 1'b0;
      psu_code  <= VBASE + VSTEP;
      reg_rdata <= '0;
      for (int i = 0; i <= NUM_LVL; i++) vtab[i] <= VBASE + VW'(i) * VSTEP;
    end else begin
      if (req_valid) begin
        if (req_ok) tgt_lvl <= req_lvl;
        else therm_err <= 1'b1;
      end
      if (reg_we) begin
        if (reg_addr <= AW'(NUM_LVL)) vtab[tidx] <= reg_wdata[VW-1:0];
        else if (reg_addr == AW'(A_TMO)) tmo <= reg_wdata[TW-1:0];
        else if (reg_addr == AW'(A_CTL)) {ctl_step, ctl_poll} <= reg_wdata[1:0];
      end
      if (reg_re) reg_rdata <= rd_mux;
      case (st)
        ST_IDLE: if (tgt_lvl != cur_lvl) begin
          nxt_lvl  <= hop;
          up_r     <= go_up;
          psu_code <= vtab[hop];
          psu_req  <= 1'b1;
          if (!go_up) cur_lvl <= hop;
          st <= ST_REQ;
        end
        ST_REQ: if (psu_ack) begin
          psu_req <= 1'b0;
          cnt     <= '0;
          st      <= ST_SET;
        end
        ST_SET: if (settle_done) begin
          if (up_r) cur_lvl <= nxt_lvl;
          st <= ST_IDLE;
        end else cnt <= cnt + 1'b1;
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_BAD_REQ_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ok) |=> ($stable(tgt_lvl) && therm_err)); // R2
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    therm_err |=> therm_err); // R2
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (psu_req && !psu_ack) |=> (psu_req && $stable(psu_code))); // R4
  AST_RAISE_AFTER_CONFIRM: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_lvl > $past(cur_lvl)) |-> ($past(st == ST_SET) && !psu_req)); // R5
  AST_POLL_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_poll && st == ST_SET && !psu_vdd_ok) |=> (st == ST_SET && $stable(cur_lvl))); // R6
  AST_LOWER_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_lvl < $past(cur_lvl)) |-> ($past(st == ST_IDLE) && psu_req)); // R7
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ctl_step) && cur_lvl != $past(cur_lvl)) |->
      (cur_lvl == $past(cur_lvl) + LW'(1) || cur_lvl + LW'(1) == $past(cur_lvl))); // R8
endmodule

// File: tb/dvs_level_ctrl_tb.sv
`timescale 1ns/1ps
module dvs_level_ctrl_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [7:0] req_therm = '0;
  logic [7:0] cur_therm, psu_code;
  logic therm_err, psu_req, psu_query;
  logic psu_ack = 1'b0, psu_vdd_ok = 1'b1;
  logic reg_we = 1'b0, reg_re = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [15:0] reg_wdata = '0, reg_rdata, rd;
  int checks = 0, errors = 0, acks = 0, a0;

  always #2.5 clk = ~clk;

  dvs_level_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_therm(req_therm),
    .cur_therm(cur_therm), .therm_err(therm_err), .psu_req(psu_req),
    .psu_code(psu_code), .psu_ack(psu_ack), .psu_query(psu_query),
    .psu_vdd_ok(psu_vdd_ok), .reg_we(reg_we), .reg_re(reg_re),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

  // supply model: acknowledge one cycle after seeing a request
  initial forever begin
    @(negedge clk);
    psu_ack = psu_req;
    if (psu_req) acks++;
  end

  // therm, ctl, expected level, expected code
  localparam logic [25:0] VEC [7] = '{
    {8'h0F, 2'd0, 8'h0F, 8'h60}, {8'h03, 2'd0, 8'h03, 8'h40},
    {8'hFF, 2'd1, 8'hFF, 8'hA0}, {8'h00, 2'd0, 8'h00, 8'h20},
    {8'h07, 2'd2, 8'h07, 8'h50}, {8'h01, 2'd3, 8'h01, 8'h30},
    {8'h1F, 2'd0, 8'h1F, 8'h77}};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic request(input logic [7:0] t);
    @(negedge clk); req_valid = 1'b1; req_therm = t;
    @(negedge clk); req_valid = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rdreg(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk); reg_re = 1'b1; reg_addr = a;
    @(negedge clk); d = reg_rdata; reg_re = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset level", cur_therm, 8'h01);
    check("R1 reset code", psu_code, 8'h30);
    check("R1 reset err", therm_err, 1'b0);
    check("R1 reset req", psu_req, 1'b0);

    rdreg(4'd3, rd);  check("R3 table reset read", rd, 16'h0050);
    rdreg(4'd9, rd);  check("R12 timeout reset", rd, 16'd4);
    rdreg(4'd10, rd); check("R12 control reset", rd, 16'd0);
    rdreg(4'd11, rd); check("R11 revision", rd, 16'h0102);
    wr(4'd11, 16'hFFFF);
    rdreg(4'd11, rd); check("R11 revision after write", rd, 16'h0102);

    a0 = acks;
    request(8'h05);
    check("R2 err set", therm_err, 1'b1);
    repeat (20) @(negedge clk);
    check("R2 level kept", cur_therm, 8'h01);
    check("R2 no supply activity", acks, a0);
    check("R2 err sticky", therm_err, 1'b1);

    wr(4'd9, 16'd3);
    rdreg(4'd9, rd); check("R12 timeout read", rd, 16'd3);
    request(8'h03);
    @(negedge clk);
    check("R4 req raised", psu_req, 1'b1);
    check("R4 code", psu_code, 8'h40);
    @(negedge clk);
    check("R4 req dropped after ack", psu_req, 1'b0);
    repeat (3) @(negedge clk);
    check("R5 not early", cur_therm, 8'h01);
    @(negedge clk);
    check("R5 on time", cur_therm, 8'h03);
    repeat (4) @(negedge clk);

    request(8'h01);
    check("R7 before edge", cur_therm, 8'h03);
    @(negedge clk);
    check("R7 level first", cur_therm, 8'h01);
    check("R7 req with low code", psu_req, 1'b1);
    check("R7 low code", psu_code, 8'h30);
    repeat (20) @(negedge clk);

    wr(4'd10, 16'd1);
    psu_vdd_ok = 1'b0;
    request(8'h0F);
    repeat (20) @(negedge clk);
    check("R6 waits for ready", cur_therm, 8'h01);
    check("R6 query", psu_query, 1'b1);
    psu_vdd_ok = 1'b1;
    @(negedge clk);
    check("R6 level after ready", cur_therm, 8'h0F);
    repeat (5) @(negedge clk);

    wr(4'd10, 16'd2);
    a0 = acks;
    request(8'hFF);
    repeat (5) @(negedge clk);
    check("R8 hop not early", cur_therm, 8'h0F);
    @(negedge clk);
    check("R8 intermediate level", cur_therm, 8'h1F);
    repeat (40) @(negedge clk);
    check("R8 final level", cur_therm, 8'hFF);
    check("R8 one ack per hop", acks - a0, 4);

    wr(4'd10, 16'd0);
    wr(4'd9, 16'd10);
    request(8'h01);
    repeat (30) @(negedge clk);
    a0 = acks;
    request(8'h03);
    request(8'h0F);
    request(8'h3F);
    repeat (5) @(negedge clk);
    check("R10 no jump mid transition", cur_therm, 8'h01);
    repeat (60) @(negedge clk);
    check("R10 latest serviced", cur_therm, 8'h3F);
    check("R10 latest code", psu_code, 8'h80);
    check("R10 two transitions", acks - a0, 2);

    wr(4'd9, 16'd4);
    wr(4'd5, 16'h0077);
    rdreg(4'd5, rd); check("R3 table write read", rd, 16'h0077);
    for (int i = 0; i < 7; i++) begin
      wr(4'd10, {14'd0, VEC[i][17:16]});
      request(VEC[i][25:18]);
      repeat (100) @(negedge clk);
      check($sformatf("R1 R9 R3 vector %0d level", i), cur_therm, VEC[i][15:8]);
      check($sformatf("R4 R9 R3 vector %0d code", i), psu_code, VEC[i][7:0]);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule